// File: doc/BRIEF.md
# Device Configuration Sequencer

This block runs the control side of loading a configuration image into an attached programmable device. A one-cycle start pulse makes it decode the device's mode-select pins into a configuration bus width and a clock-to-data ratio. It then enables the device, takes over the configuration lines and holds the device's configuration reset until the device reports its reset phase. After releasing the reset, it waits for the device to report its configuration phase. At that point it clears the monitor interrupts and opens the data path so that an external streaming engine can push image words.

When the streaming engine reports that the last word has been written, the sequencer samples the device's done and status pins. It then asks an external clock generator for a short burst of clocks so the device can reach its init phase, and for a long burst so it can reach user mode. Finally it hands the configuration lines back. Every wait is bounded by a timeout. A failed step ends the run with a one-cycle error pulse that carries a code for that step. A successful run ends with a one-cycle done pulse. In both cases the sequencer returns to idle with its line drive released.

Top module: `cfg_sequencer`

## Requirements
- R1: On the cycle after an accepted start, `width32` equals bit 3 of `mode_sel`, where 1 means a 32-bit bus and 0 means a 16-bit bus. The value holds until the next accepted start.
- R2: On the cycle after an accepted start, `cd_ratio` is decoded from `mode_sel[1:0]`. With bit 3 set, codes 0, 1 and 2 give 1, 4 and 8. With bit 3 clear, they give 1, 2 and 4. Code 3 gives 1 in both cases.
- R3: A start pulse seen while idle makes `ce_n` low and both `drive_en` and `cfg_pull` high on the next cycle, and `busy` rises. A start pulse seen while busy has no effect.
- R4: While waiting for the reset phase, `cfg_pull` drops on the cycle after `phase` equals 0. The sequencer then waits for `phase` equal to 1. Any other phase value leaves it waiting.
- R5: On the cycle after `phase` equals 1 in the configuration wait, `irq_clear` pulses for exactly one cycle with `irq_clear_mask` all ones (12 bits), and `datapath_en` rises. At all other times `irq_clear_mask` is zero.
- R6: When `stream_end` is seen with `cfg_done_pin` or `cfg_status_pin` high, the next cycle has `datapath_en` low and a one-cycle `burst_req` with `burst_len` = 4. If both pins are low, the run fails with code 3.
- R7: After `burst_done` for the first burst, phase 2 (init) or phase 3 (user) is accepted. The next cycle carries a one-cycle `burst_req` with `burst_len` = 0x5000.
- R8: After `burst_done` for the second burst, phase 3 produces a one-cycle `done` pulse on the next cycle. On that same cycle `drive_en`, `cfg_pull` and `datapath_en` are low, `ce_n` is high and `busy` is low.
- R9: Each wait fails when its condition has not been met for TIMEOUT cycles after the wait was entered. The error codes are: 1 reset-phase wait, 2 configuration-phase wait, 4 end-of-stream wait, 5 first burst, 6 init wait, 7 second burst, 8 user-mode wait.
- R10: A failure gives a one-cycle `err_valid` with its code on `err_code`. On that same cycle the line drive, the pull and the data path are off, `ce_n` is high and the sequencer is idle, so a new start is accepted. `err_code` is 0 whenever `err_valid` is low, and `done` never coincides with `err_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a configuration run |
| mode_sel | input | 4 | Device mode-select pins |
| phase | input | 3 | Phase code reported by the device (0 reset, 1 configuration, 2 init, 3 user) |
| cfg_done_pin | input | 1 | Device configuration-done pin |
| cfg_status_pin | input | 1 | Device status pin |
| stream_end | input | 1 | Streaming engine has written the last image word |
| burst_done | input | 1 | Clock generator has finished the requested burst |
| ce_n | output | 1 | Device chip enable, active low |
| drive_en | output | 1 | Sequencer drives the configuration lines |
| cfg_pull | output | 1 | Holds the device's configuration reset |
| width32 | output | 1 | Configuration bus width is 32 bits (else 16) |
| cd_ratio | output | 4 | Clock-to-data ratio (1, 2, 4 or 8) |
| irq_clear | output | 1 | One-cycle monitor interrupt clear strobe |
| irq_clear_mask | output | 12 | Interrupt bits cleared by the strobe |
| datapath_en | output | 1 | Data path open for streamed words |
| burst_req | output | 1 | One-cycle clock-burst request |
| burst_len | output | 16 | Clock count of the requested burst |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle success pulse |
| err_valid | output | 1 | One-cycle failure pulse |
| err_code | output | 4 | Failed step code (1 to 8), zero otherwise |

## Verification
The assertions assume the clock generator raises `burst_done` only while a burst is outstanding. They also assume that `start`, `stream_end` and `burst_done` are single-cycle strobes. The bench follows this by pulsing each strobe for one cycle at the moment the sequencer waits for it. Phase codes outside 0 to 3 are applied on purpose to confirm that the waits ignore them. The timeout is set to a small value on the bench so that every timeout step can be reached and its exact cycle count checked.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_WAIT,
        S_CFG_WAIT,
        S_STREAM,
        S_BURST_A,
        S_INIT_WAIT,
        S_BURST_B,
        S_USER_WAIT
    } seq_state_e;

    localparam int PHASE_W = 3;
    localparam logic [PHASE_W-1:0] PH_RESET = 3'd0;
    localparam logic [PHASE_W-1:0] PH_CONFIG = 3'd1;
    localparam logic [PHASE_W-1:0] PH_INIT = 3'd2;
    localparam logic [PHASE_W-1:0] PH_USER = 3'd3;

    localparam int ERR_W = 4;
    localparam logic [ERR_W-1:0] ERR_NONE = 4'd0;
    localparam logic [ERR_W-1:0] ERR_RESET = 4'd1;
    localparam logic [ERR_W-1:0] ERR_CONFIG = 4'd2;
    localparam logic [ERR_W-1:0] ERR_PINS = 4'd3;
    localparam logic [ERR_W-1:0] ERR_STREAM = 4'd4;
    localparam logic [ERR_W-1:0] ERR_BURST_A = 4'd5;
    localparam logic [ERR_W-1:0] ERR_INIT = 4'd6;
    localparam logic [ERR_W-1:0] ERR_BURST_B = 4'd7;
    localparam logic [ERR_W-1:0] ERR_USER = 4'd8;

    localparam int MODE_W = 4;
    localparam int RATIO_W = 4;

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
    import cfg_seq_pkg::*;
(
    input  logic [MODE_W-1:0]  mode_sel,
    output logic               wide,
    output logic [RATIO_W-1:0] ratio
);
    // Bit 3 picks the bus width and scales the ratio table by two.
    always_comb begin
        wide = mode_sel[3];
        unique case (mode_sel[1:0])
            2'd1:    ratio = mode_sel[3] ? RATIO_W'(4) : RATIO_W'(2);
            2'd2:    ratio = mode_sel[3] ? RATIO_W'(8) : RATIO_W'(4);
            default: ratio = RATIO_W'(1);
        endcase
    end

    always_comb begin
        assert (ratio == RATIO_W'(1) || ratio == RATIO_W'(2) ||
                ratio == RATIO_W'(4) || ratio == RATIO_W'(8))
            else $error("p_ratio_legal_r2: ratio %0d", ratio);
    end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int TIMEOUT = 32'h100_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LAST);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_clr_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/cfg_sequencer.sv
module cfg_sequencer
    import cfg_seq_pkg::*;
#(
    parameter int TIMEOUT    = 32'h100_0000,
    parameter int BURST_W    = 16,
    parameter int BURST_INIT = 4,
    parameter int BURST_USER = 16'h5000,
    parameter int IRQ_W      = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MODE_W-1:0]    mode_sel,
    input  logic [PHASE_W-1:0]   phase,
    input  logic                 cfg_done_pin,
    input  logic                 cfg_status_pin,
    input  logic                 stream_end,
    input  logic                 burst_done,
    output logic                 ce_n,
    output logic                 drive_en,
    output logic                 cfg_pull,
    output logic                 width32,
    output logic [RATIO_W-1:0]   cd_ratio,
    output logic                 irq_clear,
    output logic [IRQ_W-1:0]     irq_clear_mask,
    output logic                 datapath_en,
    output logic                 burst_req,
    output logic [BURST_W-1:0]   burst_len,
    output logic                 busy,
    output logic                 done,
    output logic                 err_valid,
    output logic [ERR_W-1:0]     err_code
);
    localparam logic [BURST_W-1:0] LEN_A = BURST_W'(BURST_INIT);
    localparam logic [BURST_W-1:0] LEN_B = BURST_W'(BURST_USER);

    typedef struct packed {
        seq_state_e           st;
        logic                 ce_n;
        logic                 drive;
        logic                 pull;
        logic                 w32;
        logic [RATIO_W-1:0]   ratio;
        logic                 dp_en;
        logic                 irq_clr;
        logic                 breq;
        logic [BURST_W-1:0]   blen;
        logic                 done;
        logic                 err_v;
        logic [ERR_W-1:0]     err_code;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic               dec_w32;
    logic [RATIO_W-1:0] dec_ratio;
    logic               expired;
    logic               tmr_clr;
    logic               fail;
    logic [ERR_W-1:0]   fail_code;

    cfg_mode_decode u_decode (
        .mode_sel (mode_sel),
        .wide     (dec_w32),
        .ratio    (dec_ratio)
    );

    cfg_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .expired (expired)
    );

    always_comb begin
        r_d          = r_q;
        r_d.irq_clr  = 1'b0;
        r_d.breq     = 1'b0;
        r_d.done     = 1'b0;
        r_d.err_v    = 1'b0;
        r_d.err_code = ERR_NONE;
        fail         = 1'b0;
        fail_code    = ERR_NONE;

        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st    = S_RST_WAIT;
                    r_d.w32   = dec_w32;
                    r_d.ratio = dec_ratio;
                    r_d.ce_n  = 1'b0;
                    r_d.drive = 1'b1;
                    r_d.pull  = 1'b1;
                end
            end
            S_RST_WAIT: begin
                if (phase == PH_RESET) begin
                    r_d.pull = 1'b0;
                    r_d.st   = S_CFG_WAIT;
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_RESET;
                end
            end
            S_CFG_WAIT: begin
                if (phase == PH_CONFIG) begin
                    r_d.irq_clr = 1'b1;
                    r_d.dp_en   = 1'b1;
                    r_d.st      = S_STREAM;
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_CONFIG;
                end
            end
            S_STREAM: begin
                if (stream_end) begin
                    if (cfg_done_pin || cfg_status_pin) begin
                        r_d.dp_en = 1'b0;
                        r_d.breq  = 1'b1;
                        r_d.blen  = LEN_A;
                        r_d.st    = S_BURST_A;
                    end else begin
                        fail      = 1'b1;
                        fail_code = ERR_PINS;
                    end
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_STREAM;
                end
            end
            S_BURST_A: begin
                if (burst_done) begin
                    r_d.st = S_INIT_WAIT;
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_BURST_A;
                end
            end
            S_INIT_WAIT: begin
                if (phase == PH_INIT || phase == PH_USER) begin
                    r_d.breq = 1'b1;
                    r_d.blen = LEN_B;
                    r_d.st   = S_BURST_B;
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_INIT;
                end
            end
            S_BURST_B: begin
                if (burst_done) begin
                    r_d.st = S_USER_WAIT;
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_BURST_B;
                end
            end
            S_USER_WAIT: begin
                if (phase == PH_USER) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.drive = 1'b0;
                    r_d.pull  = 1'b0;
                    r_d.dp_en = 1'b0;
                    r_d.ce_n  = 1'b1;
                end else if (expired) begin
                    fail      = 1'b1;
                    fail_code = ERR_USER;
                end
            end
            default: r_d.st = S_IDLE;
        endcase

        if (fail) begin
            r_d.st       = S_IDLE;
            r_d.err_v    = 1'b1;
            r_d.err_code = fail_code;
            r_d.drive    = 1'b0;
            r_d.pull     = 1'b0;
            r_d.dp_en    = 1'b0;
            r_d.ce_n     = 1'b1;
            r_d.breq     = 1'b0;
            r_d.irq_clr  = 1'b0;
        end
    end

    // Every wait restarts its window on entry; idle keeps the timer parked.
    assign tmr_clr = (r_d.st != r_q.st) || (r_q.st == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= S_IDLE;
            r_q.ce_n     <= 1'b1;
            r_q.ratio    <= RATIO_W'(1);
            r_q.err_code <= ERR_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign ce_n           = r_q.ce_n;
    assign drive_en       = r_q.drive;
    assign cfg_pull       = r_q.pull;
    assign width32        = r_q.w32;
    assign cd_ratio       = r_q.ratio;
    assign irq_clear      = r_q.irq_clr;
    assign irq_clear_mask = r_q.irq_clr ? {IRQ_W{1'b1}} : '0;
    assign datapath_en    = r_q.dp_en;
    assign burst_req      = r_q.breq;
    assign burst_len      = r_q.blen;
    assign busy           = (r_q.st != S_IDLE);
    assign done           = r_q.done;
    assign err_valid      = r_q.err_v;
    assign err_code       = r_q.err_code;

    p_pull_needs_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pull |-> (drive_en && !ce_n));
    p_start_takes_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (drive_en && cfg_pull && !ce_n && busy));
    p_dp_needs_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        datapath_en |-> (drive_en && !cfg_pull));
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> !irq_clear);
    p_burst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |-> (burst_len == LEN_A || burst_len == LEN_B));
    p_burst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_req |=> !burst_req);
    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!drive_en && !cfg_pull && !datapath_en && ce_n && !busy));
    p_err_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (!drive_en && !cfg_pull && !datapath_en && ce_n && !busy));
    p_err_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid ? (err_code >= ERR_RESET && err_code <= ERR_USER)
                  : (err_code == ERR_NONE));
    p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_valid, burst_req, irq_clear}));
    p_mode_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(width32) || !busy);
endmodule

// File: tb/cfg_sequencer_bench.sv
module cfg_sequencer_bench;
    localparam int TO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode_sel = 4'd0;
    logic [2:0]  phase = 3'd7;
    logic        cfg_done_pin = 1'b0;
    logic        cfg_status_pin = 1'b0;
    logic        stream_end = 1'b0;
    logic        burst_done = 1'b0;
    logic        ce_n, drive_en, cfg_pull, width32, irq_clear, datapath_en;
    logic        burst_req, busy, done, err_valid;
    logic [3:0]  cd_ratio, err_code;
    logic [11:0] irq_clear_mask;
    logic [15:0] burst_len;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cfg_sequencer #(.TIMEOUT(TO)) u_cfg_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
        .phase(phase), .cfg_done_pin(cfg_done_pin),
        .cfg_status_pin(cfg_status_pin), .stream_end(stream_end),
        .burst_done(burst_done), .ce_n(ce_n), .drive_en(drive_en),
        .cfg_pull(cfg_pull), .width32(width32), .cd_ratio(cd_ratio),
        .irq_clear(irq_clear), .irq_clear_mask(irq_clear_mask),
        .datapath_en(datapath_en), .burst_req(burst_req),
        .burst_len(burst_len), .busy(busy), .done(done),
        .err_valid(err_valid), .err_code(err_code)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    // Advance a fresh run into the wait for stage s (1 reset .. 7 user).
    task automatic go_stage(input int s);
        phase = 3'd7;
        pulse_start();
        if (s >= 2) begin phase = 3'd0; tick(); phase = 3'd7; end
        if (s >= 3) begin phase = 3'd1; tick(); phase = 3'd7; end
        if (s >= 4) begin
            stream_end = 1'b1; cfg_done_pin = 1'b1; tick();
            stream_end = 1'b0; cfg_done_pin = 1'b0;
        end
        if (s >= 5) begin burst_done = 1'b1; tick(); burst_done = 1'b0; end
        if (s >= 6) begin phase = 3'd2; tick(); phase = 3'd7; end
        if (s >= 7) begin burst_done = 1'b1; tick(); burst_done = 1'b0; end
    endtask

    task automatic t_reset;
        check(ce_n == 1'b1, "R3", "reset ce_n", int'(ce_n), 1);
        check(!drive_en && !cfg_pull && !busy, "R3", "reset drive/pull/busy",
              int'({drive_en, cfg_pull, busy}), 0);
        check(!done && !err_valid && err_code == 4'd0, "R10", "reset events",
              int'({done, err_valid, err_code}), 0);
        check(irq_clear_mask == 12'd0, "R5", "reset mask", int'(irq_clear_mask), 0);
    endtask

    task automatic t_decode;
        for (int m = 0; m < 16; m++) begin
            int exp_r;
            mode_sel = 4'(m);
            unique case (m & 3)
                1: exp_r = (m & 8) ? 4 : 2;
                2: exp_r = (m & 8) ? 8 : 4;
                default: exp_r = 1;
            endcase
            go_stage(1);
            mode_sel = ~4'(m);
            check(width32 == m[3], "R1", "width32", int'(width32), m[3]);
            check(int'(cd_ratio) == exp_r, "R2", "cd_ratio", int'(cd_ratio), exp_r);
            check(!ce_n && drive_en && cfg_pull && busy, "R3", "lines taken",
                  int'({ce_n, drive_en, cfg_pull, busy}), 7);
            for (int i = 0; i < TO; i++) begin
                if (err_valid) break;
                tick();
            end
            check(err_valid && err_code == 4'd1, "R9", "decode run end code",
                  int'(err_code), 1);
            tick();
        end
        mode_sel = 4'd0;
    endtask

    task automatic t_success(input bit direct_user, input bit use_status);
        int n;
        go_stage(1);
        phase = 3'd5; tick(); tick();
        check(cfg_pull == 1'b1, "R4", "foreign phase ignored in reset wait",
              int'(cfg_pull), 1);
        phase = 3'd0; tick(); phase = 3'd6;
        check(!cfg_pull && drive_en, "R4", "pull released", int'(cfg_pull), 0);
        start = 1'b1; tick(); start = 1'b0; tick();
        check(!cfg_pull && !datapath_en, "R3", "start while busy ignored",
              int'({cfg_pull, datapath_en}), 0);
        phase = 3'd1; tick(); phase = 3'd7;
        check(irq_clear && irq_clear_mask == 12'hFFF, "R5", "irq clear mask",
              int'(irq_clear_mask), 'hFFF);
        check(datapath_en == 1'b1, "R5", "datapath open", int'(datapath_en), 1);
        tick();
        check(!irq_clear && irq_clear_mask == 12'd0, "R5", "irq single pulse",
              int'(irq_clear), 0);
        if (use_status) cfg_status_pin = 1'b1; else cfg_done_pin = 1'b1;
        stream_end = 1'b1; tick();
        stream_end = 1'b0; cfg_status_pin = 1'b0; cfg_done_pin = 1'b0;
        check(burst_req && burst_len == 16'd4, "R6", "first burst",
              int'(burst_len), 4);
        check(!datapath_en, "R6", "datapath closed", int'(datapath_en), 1'b0);
        tick();
        check(!burst_req, "R6", "burst single pulse", int'(burst_req), 0);
        burst_done = 1'b1; tick(); burst_done = 1'b0;
        phase = direct_user ? 3'd3 : 3'd2; tick();
        check(burst_req && burst_len == 16'h5000, "R7", "second burst",
              int'(burst_len), 'h5000);
        phase = 3'd2;
        burst_done = 1'b1; tick(); burst_done = 1'b0;
        tick(); tick();
        check(busy && !done, "R8", "user wait holds on init", int'(done), 0);
        phase = 3'd3; n = 0;
        tick();
        check(done && !drive_en && ce_n && !busy && !cfg_pull, "R8", "done release",
              int'({done, drive_en, ce_n, busy}), 'b1010);
        tick();
        check(!done, "R8", "done single pulse", int'(done), 0);
        phase = 3'd7;
    endtask

    task automatic t_pin_error;
        go_stage(3);
        stream_end = 1'b1; tick(); stream_end = 1'b0;
        check(err_valid && err_code == 4'd3, "R6", "both pins low error",
              int'(err_code), 3);
        check(!burst_req && !busy && !drive_en && ce_n, "R10", "release on error",
              int'({burst_req, busy, drive_en}), 0);
        tick();
        check(!err_valid && err_code == 4'd0, "R10", "error single pulse",
              int'(err_code), 0);
    endtask

    task automatic t_timeouts;
        for (int s = 1; s <= 7; s++) begin
            int exp_c, got_at;
            exp_c = (s <= 2) ? s : s + 1;
            go_stage(s);
            got_at = -1;
            for (int i = 1; i <= TO + 4; i++) begin
                tick();
                if (err_valid) begin got_at = i; break; end
            end
            check(got_at == TO, "R9", "timeout cycle count", got_at, TO);
            check(int'(err_code) == exp_c, "R9", "timeout code", int'(err_code), exp_c);
            check(!drive_en && ce_n && !busy, "R10", "timeout release",
                  int'({drive_en, busy}), 0);
            tick();
        end
    endtask

    task automatic t_restart;
        go_stage(1);
        check(busy && cfg_pull, "R10", "restart after error accepted",
              int'({busy, cfg_pull}), 3);
        for (int i = 0; i < TO + 2; i++) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_decode();
        t_success(1'b0, 1'b0);
        t_success(1'b1, 1'b1);
        t_pin_error();
        t_timeouts();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule